// File: doc/BRIEF.md
# Strobe-Triggered Memory-Mapped Register Responder

This block answers filtered bus accesses for a peripheral that exposes up to 64 byte-wide registers. A read strobe and a write strobe arrive active-high from an external address filter, together with a 6-bit register index and an 8-bit data byte. The block brings each strobe into its own clock domain and acts once per rising edge. It then latches the index and data and passes them to a write handler or a read handler. The write handler stores the byte into the indexed register. The read handler puts the register's contents on the data output and raises an enable for an external tri-state driver. The enable stays high only while the synchronised read strobe is high, so the bus is left undriven at all other times.

A local port reads and writes the same register file between bus accesses. It has its own address, write enable and data. The ports use fixed widths: a 6-bit index and 8-bit data. The number of mapped registers and the read-only set are parameters. An index at or above the mapped count is unmapped.

Top module: `mmio_strobe_responder`

## Requirements
- R1: After reset, bus_oe is 0 and bus_dout is 0x00. Every mapped register holds 0x00, as seen through loc_rdata.
- R2: Each strobe passes through a two-flop synchroniser. A strobe held high for any number of cycles causes exactly one access. A write strobe that stays high does not store its byte again.
- R3: Let edge n be the first clock edge that samples a read strobe high. bus_oe and bus_dout are updated by edge n+3 and not earlier, which is at most 80 ns at 50 MHz.
- R4: For a write strobe first sampled high at edge n, bus_idx and bus_din are sampled at edge n+2. The byte is stored into the indexed register at edge n+3.
- R5: A read puts the indexed register's contents on bus_dout and asserts bus_oe. Both index and data are sampled at edge n+2, as for a write.
- R6: Let edge m be the first edge that samples the read strobe low. bus_oe goes low after edge m+2. bus_oe is never asserted for a read strobe that was not sampled high at both edge n and edge n+1.
- R7: Registers whose bit is set in the read-only mask ignore bus writes but accept local writes. By default the read-only registers are indices 40 to 47.
- R8: Indices from the mapped count upward are unmapped (by default 48 to 63). They read as 0xFF on both the bus and the local port, and writes to them are ignored.
- R9: A local write (loc_we high at a clock edge) stores loc_wdata at loc_addr on that edge. loc_rdata shows the register at loc_addr combinationally.
- R10: When a bus write and a local write reach the same register on the same edge, the bus byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd_stb | input | 1 | Filtered read strobe, active high, asynchronous |
| bus_wr_stb | input | 1 | Filtered write strobe, active high, asynchronous |
| bus_idx | input | 6 | Register index from the address filter |
| bus_din | input | 8 | Data byte from the bus |
| bus_dout | output | 8 | Data byte for the external driver |
| bus_oe | output | 1 | Enable for the external tri-state driver |
| loc_addr | input | 6 | Local-side register index |
| loc_we | input | 1 | Local-side write enable |
| loc_wdata | input | 8 | Local-side write data |
| loc_rdata | output | 8 | Register at loc_addr, 0xFF if unmapped |

## Verification
The bench targets several corner cases, each paired with the failure it would expose:
- A read strobe one cycle long. A design that raises the enable without checking the strobe level would drive the bus after the host has let go of it.
- A write strobe held for many cycles while the local side overwrites the same register. A level-triggered design would write the bus byte again and erase the local value.
- A bus write and a local write that land on the same register in the same cycle. A design with the wrong priority keeps the local byte.
- Writes to read-only and unmapped indices, and reads of unmapped indices. A design that does not decode these would change protected registers or return stale bytes instead of 0xFF.
- The exact release edge of the enable, checked against edge-counted expectations. A late release would leave the bus driven after the strobe ends.

// File: rtl/mmio_resp_pkg.sv
package mmio_resp_pkg;

  // True when a register index falls inside the mapped register range.
  function automatic logic idx_mapped(input int idx, input int nregs);
    return (idx >= 0) && (idx < nregs);
  endfunction

  // Worst-case strobe-to-data delay in ns for a given sync depth and clock period.
  function automatic int resp_delay_ns(input int stages, input int period_ns);
    return (stages + 2) * period_ns;
  endfunction

endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], stb};
      last  <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~last;

  // One action per access: a rising-edge pulse never lasts two cycles.
  assert_single_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/access_latch.sv
module access_latch #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_rise,
  input  logic              wr_rise,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] din,
  output logic              rd_go,
  output logic              wr_go,
  output logic [IDX_W-1:0]  hold_idx,
  output logic [DATA_W-1:0] hold_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_go     <= 1'b0;
      wr_go     <= 1'b0;
      hold_idx  <= '0;
      hold_data <= '0;
    end else begin
      rd_go <= rd_rise;
      wr_go <= wr_rise;
      if (rd_rise || wr_rise) begin
        hold_idx  <= idx;
        hold_data <= din;
      end
    end
  end

  // R4: the held index and data stay put while no new access is detected.
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_rise && !wr_rise) |=> ($stable(hold_idx) && $stable(hold_data)));
endmodule

// File: rtl/reg_cell.sv
module reg_cell #(
  parameter int DATA_W    = 8,
  parameter bit READ_ONLY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_hit,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              loc_hit,
  input  logic [DATA_W-1:0] loc_data,
  output logic [DATA_W-1:0] q
);
  logic bus_take;
  assign bus_take = bus_hit & ~READ_ONLY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (bus_take) q <= bus_data;
    else if (loc_hit)  q <= loc_data;
  end

  if (READ_ONLY) begin : g_ro_chk
    assert_ro_ignores_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hit && !loc_hit) |=> $stable(q));
  end else begin : g_rw_chk
    assert_bus_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hit && loc_hit) |=> (q == $past(bus_data)));
  end
endmodule

// File: rtl/read_handler.sv
module read_handler #(
  parameter int IDX_W    = 6,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 48
) (
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  input  logic [IDX_W-1:0]           idx,
  output logic [DATA_W-1:0]          value
);
  always_comb begin
    value = '1;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) value = regs_flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/mmio_strobe_responder.sv
module mmio_strobe_responder
  import mmio_resp_pkg::*;
#(
  parameter int                  IDX_W       = 6,
  parameter int                  DATA_W      = 8,
  parameter int                  NUM_REGS    = 48,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [NUM_REGS-1:0] RO_MASK     = 48'hFF00_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd_stb,
  input  logic              bus_wr_stb,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic [IDX_W-1:0]  loc_addr,
  input  logic              loc_we,
  input  logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] loc_rdata
);
  localparam int FLAT_W = NUM_REGS * DATA_W;

  logic rd_lvl, rd_rise, wr_lvl, wr_rise;
  logic rd_go, wr_go;
  logic [IDX_W-1:0]    hold_idx;
  logic [DATA_W-1:0]   hold_data;
  logic [FLAT_W-1:0]   regs_flat;
  logic [NUM_REGS-1:0] bus_hit, loc_hit;
  logic [DATA_W-1:0]   rd_value;
  logic [DATA_W-1:0]   dout_q;
  logic                oe_q;

  strobe_edge_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .stb(bus_rd_stb), .lvl(rd_lvl), .rise(rd_rise));

  strobe_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .stb(bus_wr_stb), .lvl(wr_lvl), .rise(wr_rise));

  access_latch #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .rd_rise(rd_rise), .wr_rise(wr_rise),
    .idx(bus_idx), .din(bus_din), .rd_go(rd_go), .wr_go(wr_go),
    .hold_idx(hold_idx), .hold_data(hold_data));

  // Write handler set: one decoded entry per mapped register.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign bus_hit[g] = wr_go  && (hold_idx == IDX_W'(g));
    assign loc_hit[g] = loc_we && (loc_addr == IDX_W'(g));
    reg_cell #(.DATA_W(DATA_W), .READ_ONLY(RO_MASK[g])) u_cell (
      .clk(clk), .rst_n(rst_n),
      .bus_hit(bus_hit[g]), .bus_data(hold_data),
      .loc_hit(loc_hit[g]), .loc_data(loc_wdata),
      .q(regs_flat[g*DATA_W +: DATA_W]));
  end

  // Read handler set for the bus side and for the local side.
  read_handler #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bus_rd (
    .regs_flat(regs_flat), .idx(hold_idx), .value(rd_value));

  read_handler #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_loc_rd (
    .regs_flat(regs_flat), .idx(loc_addr), .value(loc_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (rd_go) dout_q <= rd_value;
      oe_q <= rd_lvl & (oe_q | rd_go);
    end
  end

  assign bus_dout = dout_q;
  assign bus_oe   = oe_q;

  assert_oe_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_lvl) |=> !bus_oe);

  assert_read_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && rd_lvl) |=> bus_oe);

  assert_oe_after_handler_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(rd_go));

  assert_unmapped_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !idx_mapped(int'(hold_idx), NUM_REGS)) |=> (bus_dout == {DATA_W{1'b1}}));

  assert_wr_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_lvl) |=> wr_go);
endmodule

// File: tb/mmio_strobe_responder_bench.sv
module mmio_strobe_responder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b_rd = 1'b0, b_wr = 1'b0;
  logic [5:0] b_idx = '0;
  logic [7:0] b_din = '0;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic [5:0] l_addr = '0;
  logic       l_we = 1'b0;
  logic [7:0] l_wdata = '0;
  logic [7:0] loc_rdata;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  mmio_strobe_responder u_mmio_strobe_responder (
    .clk(clk), .rst_n(rst_n), .bus_rd_stb(b_rd), .bus_wr_stb(b_wr),
    .bus_idx(b_idx), .bus_din(b_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .loc_addr(l_addr), .loc_we(l_we), .loc_wdata(l_wdata), .loc_rdata(loc_rdata));

  // ---------------- behavioural reference model ----------------
  typedef struct packed {
    logic rd; logic wr; logic [5:0] idx; logic [7:0] din;
    logic lwe; logic [5:0] la; logic [7:0] ld;
  } samp_t;

  samp_t hist[$];
  int    mem[64];
  bit    m_oe;
  int    m_dout;

  function automatic bit is_ro(int i);
    return (i >= 40) && (i <= 47);
  endfunction

  function automatic int ref_read(int i);
    return (i < 48) ? mem[i] : 255;
  endfunction

  function automatic samp_t h(int k);
    samp_t z;
    z = '0;
    if (k < hist.size()) return hist[k];
    return z;
  endfunction

  always @(posedge clk) begin
    samp_t s;
    bit    rd_start, wr_start, nxt_oe;
    int    cidx, cdat, nxt_dout;
    if (!rst_n) begin
      hist.delete();
      m_oe = 1'b0;
      m_dout = 0;
      for (int i = 0; i < 64; i++) mem[i] = 0;
    end else begin
      s = '{rd: b_rd, wr: b_wr, idx: b_idx, din: b_din, lwe: l_we, la: l_addr, ld: l_wdata};
      hist.push_front(s);
      rd_start = h(3).rd && !h(4).rd;
      wr_start = h(3).wr && !h(4).wr;
      cidx = int'(h(1).idx);
      cdat = int'(h(1).din);
      nxt_dout = rd_start ? ref_read(cidx) : m_dout;
      nxt_oe = h(2).rd && (m_oe || rd_start);
      if (s.lwe && int'(s.la) < 48) mem[int'(s.la)] = int'(s.ld);
      if (wr_start && cidx < 48 && !is_ro(cidx)) mem[cidx] = cdat;
      m_oe = nxt_oe;
      m_dout = nxt_dout;
      if (hist.size() > 8) void'(hist.pop_back());
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every clock: compare the design against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bus_oe == m_oe, {cur_tag, " model bus_oe"}, int'(bus_oe), int'(m_oe));
      chk(int'(bus_dout) == m_dout, {cur_tag, " model bus_dout"}, int'(bus_dout), m_dout);
      chk(int'(loc_rdata) == ref_read(int'(l_addr)), {cur_tag, " model loc_rdata"},
          int'(loc_rdata), ref_read(int'(l_addr)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic bus_write(int idx, int d);
    tick();
    b_idx = 6'(idx); b_din = 8'(d); b_wr = 1'b1;
    repeat (6) tick();
    b_wr = 1'b0;
    repeat (3) tick();
  endtask

  task automatic bus_read(int idx, int exp, string tag);
    tick();
    b_idx = 6'(idx); b_rd = 1'b1;
    repeat (3) tick();
    chk(bus_oe == 1'b0, "R3 no enable before edge n+3", int'(bus_oe), 0);
    tick();
    chk(bus_oe == 1'b1, "R3 enable after edge n+3", int'(bus_oe), 1);
    chk(int'(bus_dout) == exp, tag, int'(bus_dout), exp);
    repeat (3) tick();
    b_rd = 1'b0;
    repeat (2) tick();
    chk(bus_oe == 1'b1, "R6 enable held through edge m+1", int'(bus_oe), 1);
    tick();
    chk(bus_oe == 1'b0, "R6 enable released after edge m+2", int'(bus_oe), 0);
    repeat (2) tick();
  endtask

  task automatic loc_write(int a, int d);
    tick();
    l_addr = 6'(a); l_we = 1'b1; l_wdata = 8'(d);
    tick();
    l_we = 1'b0;
  endtask

  task automatic loc_check(int a, int exp, string tag);
    tick();
    l_addr = 6'(a);
    #2;
    chk(int'(loc_rdata) == exp, tag, int'(loc_rdata), exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int seen_oe;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    tick();
    cur_tag = "R1";
    chk(bus_oe == 1'b0, "R1 reset bus_oe", int'(bus_oe), 0);
    chk(bus_dout == 8'h00, "R1 reset bus_dout", int'(bus_dout), 0);
    loc_check(0, 0, "R1 reset register 0");
    loc_check(47, 0, "R1 reset register 47");

    cur_tag = "R4";
    bus_write(3, 8'h5A);
    loc_check(3, 8'h5A, "R4 bus write stored");
    cur_tag = "R5";
    bus_read(3, 8'h5A, "R5 read returns stored byte");

    cur_tag = "R9";
    loc_write(9, 8'hC3);
    loc_check(9, 8'hC3, "R9 local write visible");
    bus_read(9, 8'hC3, "R9 local write read over bus");

    cur_tag = "R7";
    loc_write(42, 8'h33);
    bus_write(42, 8'h99);
    loc_check(42, 8'h33, "R7 read-only ignores bus write");
    bus_read(42, 8'h33, "R7 read-only bus read");

    cur_tag = "R8";
    bus_write(50, 8'h77);
    bus_read(50, 8'hFF, "R8 unmapped bus read");
    loc_write(55, 8'h12);
    loc_check(60, 8'hFF, "R8 unmapped local read");
    loc_check(55, 8'hFF, "R8 unmapped local write ignored");

    cur_tag = "R10";
    tick();
    b_idx = 6'd5; b_din = 8'hA1; b_wr = 1'b1;
    repeat (3) tick();
    l_addr = 6'd5; l_wdata = 8'hB2; l_we = 1'b1;
    tick();
    l_we = 1'b0;
    #2;
    chk(loc_rdata == 8'hA1, "R10 bus write wins collision", int'(loc_rdata), 8'hA1);
    repeat (3) tick();
    b_wr = 1'b0;
    repeat (3) tick();

    cur_tag = "R2";
    tick();
    b_idx = 6'd6; b_din = 8'h44; b_wr = 1'b1;
    repeat (5) tick();
    l_addr = 6'd6; l_wdata = 8'hD7; l_we = 1'b1;
    tick();
    l_we = 1'b0;
    repeat (6) tick();
    chk(loc_rdata == 8'hD7, "R2 held write strobe acts once", int'(loc_rdata), 8'hD7);
    b_wr = 1'b0;
    repeat (4) tick();
    bus_read(6, 8'hD7, "R2 register after long strobe");

    cur_tag = "R6";
    tick();
    b_idx = 6'd3; b_rd = 1'b1;
    tick();
    b_rd = 1'b0;
    seen_oe = 0;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (bus_oe) seen_oe++;
    end
    chk(seen_oe == 0, "R6 one-cycle read strobe never drives", seen_oe, 0);

    cur_tag = "R4";
    for (int i = 0; i < 48; i++) bus_write(i, (i * 37 + 11) & 255);
    cur_tag = "R5";
    for (int i = 0; i < 64; i += 3) begin
      int e;
      e = (i >= 48) ? 255 : (((i >= 40) && (i <= 47)) ? ref_read(i) : ((i * 37 + 11) & 255));
      bus_read(i, e, "R5 sweep read");
    end

    repeat (4) tick();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule